// File: doc/BRIEF.md
# Watchdog Timer with Shared Divider

This block is a watchdog that counts on its own free-running tick clock, separate from the core clock, so it keeps running while the core is halted in sleep. An 8-bit base counter overflows once every 256 count steps. That overflow is the undivided time-out event. The count step is one tick, or one step every `BASE_TICKS` ticks when a slower stand-in for the analog period is wanted.

A single 8-bit divider serves one of two users, chosen by a select bit. When it is assigned to the watchdog, it acts as a postscaler on the overflow event, and a 3-bit ratio field picks a tap from 1:1 to 1:128. When it is assigned to the general-purpose timer, it acts as a prescaler on that timer's source tick and the watchdog runs undivided. A time-out raises a one-tick reset request when the device is awake, or a one-tick wake-up request when it is asleep. A time-out also clears the status flag.

The clear strobe and the sleep-entry strobe both restart the watchdog. Either strobe also empties the divider when the watchdog owns it. A change of ratio does not empty the divider, so software has to clear the watchdog before it changes the ratio.

Top module: `wdt_shared_div_top`

## Requirements
- R1: After reset, `to_flag` is 1 and `wdt_reset`, `wdt_wake` are 0.
- R2: With the divider assigned to the timer (`div_to_wdt`=0) and the device awake, `wdt_reset` goes high exactly 256 ticks after the tick that took the last clear, and `to_flag` is then 0.
- R3: Each reset or wake-up request lasts exactly one tick.
- R4: A time-out while `sleep_mode`=1 raises `wdt_wake` and not `wdt_reset`.
- R5: A `clr_wdt` or `sleep_enter` strobe restarts the 256-tick count and sets `to_flag` back to 1.
- R6: When `div_to_wdt`=1, a clear strobe also empties the divider, so the next time-out comes a full 256·2^k ticks after the clear.
- R7: With `wdt_en`=0, no reset or wake-up request is ever raised and `to_flag` stays 1.
- R8: With `div_to_wdt`=1 and ratio field value k (0..7), the time-out comes 256·2^k ticks after a clear.
- R9: With `div_to_wdt`=0 and ratio k, `tmr_tick_out` pulses on every 2^k-th source tick, first on the 2^k-th after reset. With `div_to_wdt`=1, `tmr_tick_out` equals `tmr_src_tick`.
- R10: A ratio change does not empty the divider. With k=7 for three overflows and then k=2, the time-out comes 1024 ticks after the clear.
- R11: With `div_to_wdt`=0, a clear strobe leaves the divider contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running watchdog tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| sleep_enter | input | 1 | Sleep-entry strobe, clears like `clr_wdt` |
| sleep_mode | input | 1 | 1 while the core is asleep |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| div_to_wdt | input | 1 | 1: divider on watchdog; 0: divider on timer |
| ratio | input | 3 | Divider tap select, ratio 1:2^ratio |
| tmr_src_tick | input | 1 | Timer clock-source tick (one-clock pulse) |
| wdt_reset | output | 1 | One-tick device reset request |
| wdt_wake | output | 1 | One-tick wake-up request |
| to_flag | output | 1 | Status flag, 0 after a time-out |
| tmr_tick_out | output | 1 | Tick routed to the general-purpose timer |

## Verification
A base counter that is off by one step moves the request edge by a tick. Checking that the request is low one tick before the predicted edge and high exactly at it therefore exposes the fault within the first time-out period. A divider that is not emptied, or is emptied when it should not be, moves the time-out by whole overflow periods, or shifts the timer-side pulses by a source tick. Each of these shows up at the first divided event. A wrong flag or wrong request routing is visible on the tick after the time-out.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic {
      OWN_TIMER = 1'b0,
      OWN_WDT   = 1'b1
   } div_owner_e;

   localparam int unsigned DEF_CNT_W = 8;
   localparam int unsigned DEF_DIV_W = 8;
endpackage

// File: rtl/wdt_base_cnt.sv
module wdt_base_cnt #(
   parameter int unsigned CNT_W      = wdt_pkg::DEF_CNT_W,
   parameter int unsigned BASE_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   output logic ovf
);
   logic [CNT_W-1:0] cnt_q;
   logic             step;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("wdt_base_cnt: CNT_W must be at least 2");
      end
      if (BASE_TICKS < 1) begin : g_bad_t
         $error("wdt_base_cnt: BASE_TICKS must be at least 1");
      end
      if (BASE_TICKS == 1) begin : g_direct
         assign step = en;
      end else begin : g_slow
         localparam int unsigned PW = $clog2(BASE_TICKS);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 pre_q <= '0;
            else if (clr || !en)                        pre_q <= '0;
            else if (pre_q == PW'(BASE_TICKS - 1))      pre_q <= '0;
            else                                        pre_q <= pre_q + 1'b1;
         end
         assign step = en && (pre_q == PW'(BASE_TICKS - 1));
      end
   endgenerate

   assign ovf = step && !clr && (cnt_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (clr || !en) cnt_q <= '0;
      else if (step)       cnt_q <= cnt_q + 1'b1;
   end

   AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R5
   AST_NO_COUNT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/wdt_shared_div.sv
module wdt_shared_div #(
   parameter int unsigned DIV_W = wdt_pkg::DEF_DIV_W,
   localparam int unsigned SEL_W = $clog2(DIV_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  wdt_pkg::div_owner_e owner,
   input  logic [SEL_W-1:0]    sel,
   input  logic                wdt_evt,
   input  logic                tmr_evt,
   input  logic                clr,
   output logic                wdt_timeout,
   output logic                tmr_tick_out
);
   import wdt_pkg::*;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] tap_hit;
   logic             hit;
   logic             in_evt;
   logic             div_clr;

   generate
      if (DIV_W < 2 || (1 << SEL_W) != DIV_W) begin : g_bad
         $error("wdt_shared_div: DIV_W must be a power of two >= 2");
      end
      for (genvar k = 0; k < DIV_W; k++) begin : g_tap
         if (k == 0) begin : g_first
            assign tap_hit[k] = 1'b1;
         end else begin : g_rest
            assign tap_hit[k] = &div_q[k-1:0];
         end
      end
   endgenerate

   assign hit     = tap_hit[sel];
   assign in_evt  = (owner == OWN_WDT) ? wdt_evt : tmr_evt;
   assign div_clr = clr && (owner == OWN_WDT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (div_clr) div_q <= '0;
      else if (in_evt)  div_q <= div_q + 1'b1;
   end

   assign wdt_timeout  = (owner == OWN_WDT) ? (wdt_evt && hit) : wdt_evt;
   assign tmr_tick_out = (owner == OWN_WDT) ? tmr_evt : (tmr_evt && hit);

   AST_DIV_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && owner == OWN_WDT) |=> (div_q == '0)); // R6
   AST_DIV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && owner == OWN_TIMER && !tmr_evt) |=> $stable(div_q)); // R11
endmodule

// File: rtl/wdt_event_ctl.sv
module wdt_event_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic timeout,
   input  logic sleep_mode,
   input  logic clr,
   output logic wdt_reset,
   output logic wdt_wake,
   output logic to_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdt_reset <= 1'b0;
         wdt_wake  <= 1'b0;
         to_flag   <= 1'b1;
      end else begin
         wdt_reset <= timeout && !clr && !sleep_mode;
         wdt_wake  <= timeout && !clr && sleep_mode;
         if (clr)          to_flag <= 1'b1;
         else if (timeout) to_flag <= 1'b0;
      end
   end

   AST_ONE_TICK_RST: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset |=> !wdt_reset); // R3
   AST_ONE_TICK_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_wake |=> !wdt_wake); // R3
   AST_WAKE_XOR_RST: assert property (@(posedge clk) disable iff (!rst_n)
      !(wdt_reset && wdt_wake)); // R4
   AST_FLAG_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_reset || wdt_wake) |-> !to_flag); // R2
   AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (to_flag && !wdt_reset && !wdt_wake)); // R5
endmodule

// File: rtl/wdt_shared_div_top.sv
module wdt_shared_div_top #(
   parameter int unsigned CNT_W      = wdt_pkg::DEF_CNT_W,
   parameter int unsigned DIV_W      = wdt_pkg::DEF_DIV_W,
   parameter int unsigned BASE_TICKS = 1,
   localparam int unsigned SEL_W     = $clog2(DIV_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_wdt,
   input  logic             sleep_enter,
   input  logic             sleep_mode,
   input  logic             wdt_en,
   input  logic             div_to_wdt,
   input  logic [SEL_W-1:0] ratio,
   input  logic             tmr_src_tick,
   output logic             wdt_reset,
   output logic             wdt_wake,
   output logic             to_flag,
   output logic             tmr_tick_out
);
   import wdt_pkg::*;

   logic       any_clr;
   logic       base_ovf;
   logic       timeout;
   div_owner_e owner;

   assign any_clr = clr_wdt || sleep_enter;
   assign owner   = div_to_wdt ? OWN_WDT : OWN_TIMER;

   wdt_base_cnt #(.CNT_W(CNT_W), .BASE_TICKS(BASE_TICKS)) u_base (
      .clk(clk), .rst_n(rst_n), .en(wdt_en), .clr(any_clr), .ovf(base_ovf));

   wdt_shared_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .owner(owner), .sel(ratio),
      .wdt_evt(base_ovf), .tmr_evt(tmr_src_tick), .clr(any_clr),
      .wdt_timeout(timeout), .tmr_tick_out(tmr_tick_out));

   wdt_event_ctl u_evt (
      .clk(clk), .rst_n(rst_n), .timeout(timeout), .sleep_mode(sleep_mode),
      .clr(any_clr), .wdt_reset(wdt_reset), .wdt_wake(wdt_wake),
      .to_flag(to_flag));

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !wdt_en |=> !(wdt_reset || wdt_wake)); // R7
   AST_TIMER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      div_to_wdt |-> (tmr_tick_out == tmr_src_tick)); // R9
endmodule

// File: tb/wdt_shared_div_top_test.sv
module wdt_shared_div_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_wdt = 1'b0, sleep_enter = 1'b0, sleep_mode = 1'b0;
   logic       wdt_en = 1'b1, div_to_wdt = 1'b0, tmr_src_tick = 1'b0;
   logic [2:0] ratio = 3'd0;
   logic       wdt_reset, wdt_wake, to_flag, tmr_tick_out;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   wdt_shared_div_top uut (
      .clk(clk), .rst_n(rst_n), .clr_wdt(clr_wdt), .sleep_enter(sleep_enter),
      .sleep_mode(sleep_mode), .wdt_en(wdt_en), .div_to_wdt(div_to_wdt),
      .ratio(ratio), .tmr_src_tick(tmr_src_tick), .wdt_reset(wdt_reset),
      .wdt_wake(wdt_wake), .to_flag(to_flag), .tmr_tick_out(tmr_tick_out));

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic own, input logic [2:0] k);
      @(negedge clk);
      rst_n = 1'b0; clr_wdt = 0; sleep_enter = 0; sleep_mode = 0;
      wdt_en = 1; div_to_wdt = own; ratio = k; tmr_src_tick = 0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic strobe_clr(input logic use_sleep);
      if (use_sleep) sleep_enter = 1'b1; else clr_wdt = 1'b1;
      @(negedge clk);
      sleep_enter = 1'b0; clr_wdt = 1'b0;
   endtask

   // Called right after a clear strobe; checks the request edge at n ticks.
   task automatic expect_edge(input int n, input logic wake, input string req);
      repeat (n - 1) @(negedge clk);
      chk(!wdt_reset && !wdt_wake, req, wdt_reset | wdt_wake, 0);
      @(negedge clk);
      chk(wake ? (wdt_wake && !wdt_reset) : (wdt_reset && !wdt_wake),
          req, {wdt_reset, wdt_wake}, wake ? 1 : 2);
      chk(to_flag == 1'b0, req, to_flag, 0);
      @(negedge clk);
      chk(!wdt_reset && !wdt_wake, "R3", wdt_reset | wdt_wake, 0);
   endtask

   task automatic t_reset_state;
      do_reset(1'b0, 3'd0);
      chk(to_flag == 1'b1, "R1", to_flag, 1);
      chk(!wdt_reset && !wdt_wake, "R1", wdt_reset | wdt_wake, 0);
   endtask

   task automatic t_awake_timeout;
      do_reset(1'b0, 3'd5);
      strobe_clr(1'b0);
      expect_edge(256, 1'b0, "R2");
      strobe_clr(1'b0);
      chk(to_flag == 1'b1, "R5", to_flag, 1);
   endtask

   task automatic t_sleep_wake;
      do_reset(1'b0, 3'd0);
      sleep_mode = 1'b1;
      repeat (100) @(negedge clk);
      strobe_clr(1'b1);
      expect_edge(256, 1'b1, "R4");
      sleep_mode = 1'b0;
   endtask

   task automatic t_restart;
      do_reset(1'b0, 3'd0);
      repeat (200) @(negedge clk);
      strobe_clr(1'b1);
      expect_edge(256, 1'b0, "R5");
   endtask

   task automatic t_div_cleared;
      do_reset(1'b1, 3'd2);
      strobe_clr(1'b0);
      repeat (600) @(negedge clk);
      strobe_clr(1'b0);
      expect_edge(1024, 1'b0, "R6");
   endtask

   task automatic t_disabled;
      int seen = 0;
      do_reset(1'b0, 3'd0);
      wdt_en = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (wdt_reset || wdt_wake) seen++;
      end
      chk(seen == 0, "R7", seen, 0);
      chk(to_flag == 1'b1, "R7", to_flag, 1);
      wdt_en = 1'b1;
   endtask

   task automatic t_ratio(input logic [2:0] k);
      do_reset(1'b1, k);
      strobe_clr(1'b0);
      expect_edge(256 << k, 1'b0, "R8");
   endtask

   task automatic t_timer_prescale;
      do_reset(1'b0, 3'd2);
      wdt_en = 1'b0;
      for (int i = 1; i <= 8; i++) begin
         tmr_src_tick = 1'b1;
         #1;
         chk(tmr_tick_out == ((i % 4) == 0), "R9", tmr_tick_out, (i % 4) == 0);
         @(negedge clk);
         tmr_src_tick = 1'b0;
         @(negedge clk);
      end
      div_to_wdt = 1'b1;
      tmr_src_tick = 1'b1;
      #1;
      chk(tmr_tick_out == 1'b1, "R9", tmr_tick_out, 1);
      @(negedge clk);
      tmr_src_tick = 1'b0;
      #1;
      chk(tmr_tick_out == 1'b0, "R9", tmr_tick_out, 0);
      wdt_en = 1'b1;
   endtask

   task automatic t_timer_kept;
      do_reset(1'b0, 3'd2);
      wdt_en = 1'b0;
      tmr_src_tick = 1'b1;
      @(negedge clk);
      tmr_src_tick = 1'b0;
      strobe_clr(1'b0);
      for (int i = 1; i <= 3; i++) begin
         tmr_src_tick = 1'b1;
         #1;
         chk(tmr_tick_out == (i == 3), "R11", tmr_tick_out, i == 3);
         @(negedge clk);
         tmr_src_tick = 1'b0;
      end
      wdt_en = 1'b1;
   endtask

   task automatic t_early;
      do_reset(1'b1, 3'd7);
      strobe_clr(1'b0);
      repeat (770) @(negedge clk);
      ratio = 3'd2;
      expect_edge(1024 - 770, 1'b0, "R10");
   endtask

   initial begin
      t_reset_state();
      t_awake_timeout();
      t_sleep_wake();
      t_restart();
      t_div_cleared();
      t_disabled();
      t_ratio(3'd0);
      t_ratio(3'd3);
      t_ratio(3'd7);
      t_timer_prescale();
      t_timer_kept();
      t_early();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule